// File: doc/BRIEF.md
# I2C Master Interrupt Status and Enable Unit

This unit gathers the one-cycle event pulses produced by the transfer engine of a byte-oriented I2C master. It latches each pulse into a sticky flag and presents the flags on a small 16-bit register port. Software can poll a raw view that shows every latched flag. It can also read a masked view that shows only the flags whose enable bit is set. Flags are cleared by writing ones to the masked view.

Enables are never written as a whole word. One address sets the enable bits given as ones, and another address clears them. Either address reads back the enable mask, so a set or clear never needs a read-modify-write. A level-sensitive interrupt output is high while any enabled flag is set. The raw view also carries a live bus-busy level, which cannot be latched or cleared.

Event bit positions, shared by the raw view, masked view and enable mask: bit 0 arbitration lost, bit 1 no-acknowledge, bit 2 operation finished, bit 3 receive byte ready, bit 4 transmit space ready, bit 5 access error, bit 6 receive overrun. The bus-busy level is bit 12 of the raw view. Word addresses are: 0 raw view, 1 masked view / clear, 2 enable set, 3 enable clear. All accesses are full 16-bit words.

Top module: `irq_event_unit`

## Requirements
- R1: After reset every event flag and every enable bit is 0 and `irq_o` is low.
- R2: A 1 on `evt_pulse_i[b]` for one clock sets flag b. The flag appears in the raw view (address 0, bit b) from the next cycle, whatever the enable bit.
- R3: Raw-view bit 12 follows `bus_busy_i` directly. No write to address 0 or 1 changes it, and writes to address 0 change nothing.
- R4: A read of address 1 returns the event flags ANDed with the enable mask. Bit 12 and bits 7 to 15 read 0 there.
- R5: Writing address 1 clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R6: Writing 0x7FFF to address 1 clears all seven flags in one access.
- R7: Writing address 2 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. Reads of address 2 or 3 return the enable mask in bits 6:0.
- R8: Writing address 3 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R9: `irq_o` is high exactly when some flag and its enable bit are both 1. It falls in the cycle after the write that clears the last such flag or enable.
- R10: When an event pulse and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R11: Addresses 4 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 3 | Word address for read and write |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| evt_pulse_i | input | 7 | One-cycle event pulses from the transfer engine |
| bus_busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the collision between an event pulse and a clear of the same flag in a single clock. The bench cannot time this from software-like polling. Its stimulus table therefore applies the pulse and the masked-view write in the same row, then reads the raw view the following cycle. Other rows drive one flag while its enable is clear and another while its enable is set, so the raw view, the masked view and the interrupt line are seen to differ. The bus-busy level is raised only after flags are latched, so the bench can check that the live bit and the sticky bits sit side by side and that neither disturbs the other.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int IU_DATA_W   = 16;
    localparam int IU_ADDR_W   = 3;
    localparam int IU_NUM_EVT  = 7;
    localparam int IU_BUSY_BIT = 12;

    // word addresses of the register port
    localparam int IU_A_RAW    = 0;
    localparam int IU_A_MASKED = 1;
    localparam int IU_A_EN_SET = 2;
    localparam int IU_A_EN_CLR = 3;

    typedef struct packed {
        logic raw;
        logic masked;
        logic en_set;
        logic en_clr;
    } reg_sel_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_unit_pkg::*;
#(
    parameter int ADDR_W  = IU_ADDR_W,
    parameter int DATA_W  = IU_DATA_W,
    parameter int NUM_EVT = IU_NUM_EVT
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output reg_sel_t           sel_o,
    output logic [NUM_EVT-1:0] clr_mask_o,
    output logic [NUM_EVT-1:0] en_set_mask_o,
    output logic [NUM_EVT-1:0] en_clr_mask_o
);

    logic [NUM_EVT-1:0] wbits;

    assign wbits = wdata_i[NUM_EVT-1:0];

    generate
        if (NUM_EVT < DATA_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wdata_i[DATA_W-1:NUM_EVT];
        end
    endgenerate

    always_comb begin
        sel_o        = '0;
        sel_o.raw    = (int'(addr_i) == IU_A_RAW);
        sel_o.masked = (int'(addr_i) == IU_A_MASKED);
        sel_o.en_set = (int'(addr_i) == IU_A_EN_SET);
        sel_o.en_clr = (int'(addr_i) == IU_A_EN_CLR);
    end

    assign clr_mask_o    = (wr_i && sel_o.masked) ? wbits : '0;
    assign en_set_mask_o = (wr_i && sel_o.en_set) ? wbits : '0;
    assign en_clr_mask_o = (wr_i && sel_o.en_clr) ? wbits : '0;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_unit_pkg::*;
#(
    parameter int NUM_EVT = IU_NUM_EVT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_EVT; b++) begin
            // a new event outranks a clear of the same bit
            if (evt_i[b])
                st_d.flags[b] = 1'b1;
            else if (clr_i[b])
                st_d.flags[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

    // R10: clear in the same cycle never beats the event
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & clr_i)) |=> ((flags_o & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

    p_clear_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((flags_o & $past(clr_i & ~evt_i)) == '0));

    p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i)));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_unit_pkg::*;
#(
    parameter int NUM_EVT = IU_NUM_EVT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] en_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_o = st_q.en;

    p_en_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((en_o & $past(set_i)) == $past(set_i)));

    p_en_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((en_o & $past(clr_i)) == '0));

    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(en_o));

endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
    import irq_unit_pkg::*;
#(
    parameter int DATA_W   = IU_DATA_W,
    parameter int ADDR_W   = IU_ADDR_W,
    parameter int NUM_EVT  = IU_NUM_EVT,
    parameter int BUSY_BIT = IU_BUSY_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [NUM_EVT-1:0] evt_pulse_i,
    input  logic               bus_busy_i,
    output logic               irq_o
);

    reg_sel_t           sel;
    logic [NUM_EVT-1:0] clr_mask;
    logic [NUM_EVT-1:0] en_set_mask;
    logic [NUM_EVT-1:0] en_clr_mask;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] en;
    logic [NUM_EVT-1:0] pending;

    irq_reg_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_EVT(NUM_EVT)
    ) u_dec (
        .addr_i       (reg_addr_i),
        .wr_i         (reg_wr_i),
        .wdata_i      (reg_wdata_i),
        .sel_o        (sel),
        .clr_mask_o   (clr_mask),
        .en_set_mask_o(en_set_mask),
        .en_clr_mask_o(en_clr_mask)
    );

    irq_flag_bank #(
        .NUM_EVT(NUM_EVT)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse_i),
        .clr_i  (clr_mask),
        .flags_o(flags)
    );

    irq_enable_reg #(
        .NUM_EVT(NUM_EVT)
    ) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(en_set_mask),
        .clr_i(en_clr_mask),
        .en_o (en)
    );

    assign pending = flags & en;
    assign irq_o   = |pending;

    always_comb begin
        reg_rdata_o = '0;
        if (sel.raw) begin
            reg_rdata_o[NUM_EVT-1:0] = flags;
            reg_rdata_o[BUSY_BIT]    = bus_busy_i;
        end else if (sel.masked) begin
            reg_rdata_o[NUM_EVT-1:0] = pending;
        end else if (sel.en_set || sel.en_clr) begin
            reg_rdata_o[NUM_EVT-1:0] = en;
        end
    end

    // R9: a new request needs a fresh event or a fresh enable
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(|evt_pulse_i) || $past(|en_set_mask)));

    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(|clr_mask) || $past(|en_clr_mask)));

endmodule

// File: tb/tb_irq_event_unit.sv
`timescale 1ns/1ps
module tb_irq_event_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic [6:0]  evt_pulse_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_event_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr_i (reg_addr_i),
        .reg_wr_i   (reg_wr_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .evt_pulse_i(evt_pulse_i),
        .bus_busy_i (bus_busy_i),
        .irq_o      (irq_o)
    );

    // {wr_addr, wr, wdata, evt, rd_addr, exp_rdata, exp_irq}
    localparam int NV = 15;
    localparam logic [46:0] VEC [NV] = '{
        {3'd0, 1'b0, 16'h0000, 7'h09, 3'd0, 16'h0009, 1'b0}, // R2 latch, enables off
        {3'd1, 1'b1, 16'h0000, 7'h00, 3'd1, 16'h0000, 1'b0}, // R4 nothing enabled
        {3'd2, 1'b1, 16'h0008, 7'h00, 3'd1, 16'h0008, 1'b1}, // R7 R9
        {3'd2, 1'b1, 16'h0041, 7'h00, 3'd2, 16'h0049, 1'b1}, // R7 others kept
        {3'd3, 1'b1, 16'h0008, 7'h00, 3'd3, 16'h0041, 1'b1}, // R8
        {3'd1, 1'b1, 16'h0008, 7'h00, 3'd0, 16'h0001, 1'b1}, // R5 clear one
        {3'd1, 1'b1, 16'h0000, 7'h00, 3'd0, 16'h0001, 1'b1}, // R5 zeros ignored
        {3'd0, 1'b1, 16'h7FFF, 7'h00, 3'd0, 16'h0001, 1'b1}, // R3 raw write ignored
        {3'd1, 1'b1, 16'h0001, 7'h00, 3'd1, 16'h0000, 1'b0}, // R9 drop
        {3'd0, 1'b0, 16'h0000, 7'h7F, 3'd1, 16'h0041, 1'b1}, // R4 masking
        {3'd1, 1'b1, 16'h7FFF, 7'h00, 3'd0, 16'h0000, 1'b0}, // R6 clear all
        {3'd1, 1'b1, 16'h0040, 7'h40, 3'd0, 16'h0040, 1'b1}, // R10 event wins
        {3'd5, 1'b1, 16'hFFFF, 7'h00, 3'd5, 16'h0000, 1'b1}, // R11 hole
        {3'd1, 1'b1, 16'h0040, 7'h00, 3'd0, 16'h0000, 1'b0}, // R5 clear after collision
        {3'd0, 1'b0, 16'h0000, 7'h14, 3'd0, 16'h0014, 1'b0}  // R2 disabled events
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic cycle(input logic [2:0] a, input logic w, input logic [15:0] d,
                         input logic [6:0] e);
        @(negedge clk);
        reg_addr_i  = a;
        reg_wr_i    = w;
        reg_wdata_i = d;
        evt_pulse_i = e;
        @(negedge clk);
        reg_wr_i    = 1'b0;
        evt_pulse_i = '0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [15:0] exp);
        reg_addr_i = a;
        #1;
        check(req, reg_rdata_o, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, "R1 raw", 16'h0000);
        rd(3'd2, "R1 enable", 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            v = VEC[i];
            cycle(v[46:44], v[43], v[42:27], v[26:20]);
            rd(v[19:17], $sformatf("vector %0d data", i), v[16:1]);
            check($sformatf("vector %0d irq R9", i), {15'd0, irq_o}, {15'd0, v[0]});
        end

        // R3 busy level beside sticky flags (flags 0x14, enables 0x41)
        bus_busy_i = 1'b1;
        rd(3'd0, "R3 busy shown", 16'h1014);
        rd(3'd1, "R4 busy not masked", 16'h0000);
        cycle(3'd1, 1'b1, 16'h1000, 7'h00);
        cycle(3'd0, 1'b1, 16'hFFFF, 7'h00);
        rd(3'd0, "R3 busy not clearable", 16'h1014);
        bus_busy_i = 1'b0;
        rd(3'd0, "R3 busy follows level", 16'h0014);

        // R7 R9 late enable raises irq for old flags
        cycle(3'd2, 1'b1, 16'h007F, 7'h00);
        rd(3'd1, "R7 masked after set", 16'h0014);
        check("R9 irq on enable", {15'd0, irq_o}, 16'h0001);
        // R8 clearing every enable drops irq, flags kept
        cycle(3'd3, 1'b1, 16'h007F, 7'h00);
        rd(3'd3, "R8 all cleared", 16'h0000);
        rd(3'd0, "R8 flags kept", 16'h0014);
        check("R9 irq off", {15'd0, irq_o}, 16'h0000);

        // R1 reset in mid run
        cycle(3'd2, 1'b1, 16'h0003, 7'h03);
        check("R9 irq before reset", {15'd0, irq_o}, 16'h0001);
        rst_n = 1'b0;
        #1;
        rd(3'd0, "R1 flags reset", 16'h0000);
        rd(3'd2, "R1 enables reset", 16'h0000);
        check("R1 irq reset", {15'd0, irq_o}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule